// File: doc/BRIEF.md
# Guarded-Pop UART Receive Read Port

This block lets a processor read a UART receive queue through a memory-mapped port. One bus read returns the oldest received byte and its status in a single 32-bit word. The processor's output-enable (active low) and register-enable strobes are not tied to the system clock. Both strobes pass through synchronizer flops before any edge is detected.

The queue is removed from only after the bus has finished sampling, on the rising edge of output-enable. That removal is allowed only if a data-present snapshot was taken as true when register-enable rose at the start of the same access. A read of an empty queue therefore never discards a byte that lands while the strobe is still low. The register-enable edge detect and the snapshot cost two wait states, and the block signals them on a wait output.

The block also holds the 16-entry byte queue and a two-flop synchronizer for the raw serial line. Bit-level deserialization lies outside the block. It reaches the block as a byte plus a one-cycle valid pulse.

Top module: `uart_rx_readport`

## Requirements
- R1: The read word carries the head byte in bits 7:0, data-present in bit 8 and the overrun flag in bit 9. Bits 31:10 are always zero. Bits 7:0 read as zero while the queue is empty.
- R2: `data_present` is high exactly when the queue holds at least one byte. It rises on the clock edge that accepts a byte into an empty queue.
- R3: A pop happens on the third clock edge after `oe_n_async` rises (two synchronizer edges, then the edge-detect edge). Bytes leave the queue in arrival order.
- R4: A pop happens only if `data_present` was high when the synchronized register-enable rise was seen. A byte that arrives during an access that began on an empty queue stays in the queue.
- R5: `bus_wait` goes high on the third clock edge after `reg_en_async` rises. It stays high for exactly two cycles.
- R6: The queue holds 16 bytes. When the queue is full, a push and a pop on the same edge both take effect, and no byte is lost.
- R7: A push into a full queue with no pop on that edge is dropped and sets the sticky overrun flag. The next pop clears the flag.
- R8: `rx_serial_sync` follows `rx_serial_async` after two clock edges.
- R9: Synchronous active-high `rst` empties the queue and clears the snapshot, the edge detectors, the wait counter and the overrun flag.
- R10: Each access pops at most once. An output-enable pulse with no new register-enable rise pops nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_n_async | input | 1 | Bus output-enable strobe, active low, asynchronous |
| reg_en_async | input | 1 | Bus register-enable strobe, active high, asynchronous |
| rx_serial_async | input | 1 | Raw serial receive line |
| rx_serial_sync | output | 1 | Serial line after the two-stage synchronizer |
| rx_byte_valid | input | 1 | One-cycle pulse: a received byte is offered |
| rx_byte | input | 8 | Received byte |
| rd_word | output | 32 | Read word: byte, data-present, overrun |
| data_present | output | 1 | Queue not empty |
| bus_wait | output | 1 | Holds the bus access during the snapshot wait states |

## Verification
A byte offered with `rx_byte_valid` shows on `data_present` and `rd_word` one edge later. A pop takes three edges after `oe_n_async` rises. `bus_wait` starts three edges after `reg_en_async` rises and lasts two cycles. Serial data reaches `rx_serial_sync` two edges after it changes. The bench drives every input on a falling edge. It samples the read word only after four or more falling edges, once the snapshot has settled, and it waits at least five falling edges after a strobe rises before it reads the outcome. The same-edge push and pop test places the byte pulse on exactly the third rising edge after output-enable rises.

// File: rtl/uart_rdport_pkg.sv
package uart_rdport_pkg;
   localparam int WORD_W   = 32;
   localparam int BYTE_W   = 8;
   localparam int DP_BIT   = 8;
   localparam int OVR_BIT  = 9;

   function automatic logic [WORD_W-1:0] pack_word(input logic [BYTE_W-1:0] b,
                                                   input logic present,
                                                   input logic ovr);
      logic [WORD_W-1:0] w;
      w = '0;
      w[BYTE_W-1:0] = present ? b : '0;
      w[DP_BIT]     = present;
      w[OVR_BIT]    = ovr;
      return w;
   endfunction
endpackage

// File: rtl/rdport_sync.sv
module rdport_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("rdport_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain_q[0] <= RESET_VAL;
               else     chain_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain_q[i] <= RESET_VAL;
               else     chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rdport_fifo.sv
module rdport_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty,
   output logic          overrun
);
   logic [W-1:0]  mem_q [DEPTH];
   logic [AW-1:0] wr_q, rd_q, wr_nx, rd_nx;
   logic [CW-1:0] cnt_q;
   logic          ovr_q;
   logic          pop_ok, push_ok;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CW'(DEPTH));
   assign pop_ok  = pop & ~empty;
   assign push_ok = push & (~full | pop_ok);

   generate
      if (DEPTH < 2) begin : g_bad
         $error("rdport_fifo: DEPTH must be at least 2");
      end
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wr_nx = wr_q + 1'b1;
         assign rd_nx = rd_q + 1'b1;
      end else begin : g_wrap
         assign wr_nx = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
         assign rd_nx = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem_q[wr_q] <= din;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
         ovr_q <= 1'b0;
      end else begin
         if (push_ok) wr_q <= wr_nx;
         if (pop_ok)  rd_q <= rd_nx;
         case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
         if (pop_ok)                 ovr_q <= 1'b0;
         else if (push && !push_ok)  ovr_q <= 1'b1;
      end
   end

   assign head    = mem_q[rd_q];
   assign count   = cnt_q;
   assign overrun = ovr_q;
endmodule

// File: rtl/rdport_access_ctrl.sv
module rdport_access_ctrl #(
   parameter int WAIT_CYCLES = 2,
   localparam int WW = $clog2(WAIT_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic oe_n_s,
   input  logic reg_en_s,
   input  logic present,
   output logic pop,
   output logic snap,
   output logic bus_wait
);
   logic          oe_d_q, re_d_q;
   logic          snap_q, armed_q;
   logic [WW-1:0] wait_q;
   logic          oe_rise, re_rise;

   generate
      if (WAIT_CYCLES < 1) begin : g_bad
         $error("rdport_access_ctrl: WAIT_CYCLES must be at least 1");
      end
   endgenerate

   assign oe_rise = oe_n_s & ~oe_d_q;
   assign re_rise = reg_en_s & ~re_d_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         oe_d_q  <= 1'b1;
         re_d_q  <= 1'b0;
         snap_q  <= 1'b0;
         armed_q <= 1'b0;
         wait_q  <= '0;
      end else begin
         oe_d_q <= oe_n_s;
         re_d_q <= reg_en_s;
         if (re_rise)      snap_q <= present;
         else if (oe_rise) snap_q <= 1'b0;
         if (oe_rise)      armed_q <= 1'b0;
         else if (!oe_n_s) armed_q <= 1'b1;
         if (re_rise)              wait_q <= WW'(WAIT_CYCLES);
         else if (wait_q != '0)    wait_q <= wait_q - 1'b1;
      end
   end

   assign pop      = oe_rise & snap_q & armed_q;
   assign snap     = snap_q;
   assign bus_wait = (wait_q != '0);
endmodule

// File: rtl/uart_rx_readport.sv
module uart_rx_readport #(
   parameter int FIFO_DEPTH  = 16,
   parameter int SYNC_STAGES = 2,
   parameter int WAIT_CYCLES = 2,
   localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        oe_n_async,
   input  logic        reg_en_async,
   input  logic        rx_serial_async,
   output logic        rx_serial_sync,
   input  logic        rx_byte_valid,
   input  logic [7:0]  rx_byte,
   output logic [31:0] rd_word,
   output logic        data_present,
   output logic        bus_wait
);
   import uart_rdport_pkg::*;

   logic          oe_n_s, reg_en_s;
   logic          pop_w, snap_w;
   logic [7:0]    head_w;
   logic [CW-1:0] fifo_count;
   logic          fifo_full, fifo_empty, overrun_w;

   rdport_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_oe (
      .clk(clk), .rst(rst), .d(oe_n_async), .q(oe_n_s));
   rdport_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_re (
      .clk(clk), .rst(rst), .d(reg_en_async), .q(reg_en_s));
   rdport_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_ser (
      .clk(clk), .rst(rst), .d(rx_serial_async), .q(rx_serial_sync));

   rdport_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
      .clk(clk), .rst(rst), .push(rx_byte_valid), .din(rx_byte),
      .pop(pop_w), .head(head_w), .count(fifo_count), .full(fifo_full),
      .empty(fifo_empty), .overrun(overrun_w));

   rdport_access_ctrl #(.WAIT_CYCLES(WAIT_CYCLES)) u_ctrl (
      .clk(clk), .rst(rst), .oe_n_s(oe_n_s), .reg_en_s(reg_en_s),
      .present(~fifo_empty), .pop(pop_w), .snap(snap_w), .bus_wait(bus_wait));

   assign data_present = ~fifo_empty;
   assign rd_word      = pack_word(head_w, ~fifo_empty, overrun_w);
endmodule

// File: rtl/rdport_checker.sv
module rdport_checker #(
   parameter int DEPTH = 16,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst,
   input logic          push,
   input logic          full,
   input logic          pop,
   input logic          snap,
   input logic [CW-1:0] count,
   input logic          overrun,
   input logic          bus_wait,
   input logic          data_present
);
   // R5
   wait_len_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(bus_wait) |=> bus_wait ##1 !bus_wait);
   // R4
   pop_needs_snap_chk: assert property (@(posedge clk) disable iff (rst)
      pop |-> snap);
   // R10
   pop_single_chk: assert property (@(posedge clk) disable iff (rst)
      pop |=> !pop);
   // R7
   ovr_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(overrun) |-> $past(push && full && !pop));
   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      count <= CW'(DEPTH));
   // R2
   dp_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(data_present) |-> $past(push));
   // R9
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (count == '0 && !overrun && !bus_wait));
endmodule

bind uart_rx_readport rdport_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
   .clk(clk), .rst(rst), .push(rx_byte_valid), .full(fifo_full), .pop(pop_w),
   .snap(snap_w), .count(fifo_count), .overrun(overrun_w), .bus_wait(bus_wait),
   .data_present(data_present));

// File: tb/tb_uart_rx_readport.sv
module tb_uart_rx_readport;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        oe_n_async = 1'b1;
   logic        reg_en_async = 1'b0;
   logic        rx_serial_async = 1'b1;
   logic        rx_serial_sync;
   logic        rx_byte_valid = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic [31:0] rd_word;
   logic        data_present;
   logic        bus_wait;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   uart_rx_readport dut (
      .clk(clk), .rst(rst), .oe_n_async(oe_n_async), .reg_en_async(reg_en_async),
      .rx_serial_async(rx_serial_async), .rx_serial_sync(rx_serial_sync),
      .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte), .rd_word(rd_word),
      .data_present(data_present), .bus_wait(bus_wait));

   // step table: op (0 push, 1 access), byte, expected low 10 bits of read
   localparam int NSTEP = 11;
   localparam logic [18:0] STEPS [NSTEP] = '{
      {1'b0, 8'hA5, 10'h000},
      {1'b0, 8'h3C, 10'h000},
      {1'b0, 8'h00, 10'h000},
      {1'b1, 8'h00, 10'h1A5},
      {1'b1, 8'h00, 10'h13C},
      {1'b1, 8'h00, 10'h100},
      {1'b1, 8'h00, 10'h000},
      {1'b0, 8'h5A, 10'h000},
      {1'b0, 8'hFF, 10'h000},
      {1'b1, 8'h00, 10'h15A},
      {1'b1, 8'h00, 10'h1FF}
   };

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic nedges(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push_byte(input logic [7:0] b);
      @(negedge clk);
      rx_byte_valid = 1'b1;
      rx_byte = b;
      @(negedge clk);
      rx_byte_valid = 1'b0;
   endtask

   task automatic access(output logic [31:0] w);
      @(negedge clk);
      oe_n_async = 1'b0;
      reg_en_async = 1'b1;
      nedges(5);
      w = rd_word;
      oe_n_async = 1'b1;
      reg_en_async = 1'b0;
      nedges(5);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] w;
      nedges(3);
      // R9 reset state
      check(rd_word == 32'h0 && !data_present && !bus_wait, "R9 reset",
            {rd_word[31:2], data_present, bus_wait}, 32'h0);
      rst = 1'b0;
      nedges(2);

      // R8 serial synchronizer latency
      rx_serial_async = 1'b0;
      @(negedge clk);
      check(rx_serial_sync == 1'b1, "R8 one edge", 32'(rx_serial_sync), 32'h1);
      @(negedge clk);
      check(rx_serial_sync == 1'b0, "R8 two edges", 32'(rx_serial_sync), 32'h0);
      rx_serial_async = 1'b1;
      nedges(3);

      // R1 R2 R3 table walk
      for (int i = 0; i < NSTEP; i++) begin
         if (STEPS[i][18] == 1'b0) begin
            push_byte(STEPS[i][17:10]);
            check(data_present, "R2 present after push", 32'(data_present), 32'h1);
         end else begin
            access(w);
            check(w[9:0] == STEPS[i][9:0] && w[31:10] == '0, "R1 R3 read word",
                  w, 32'(STEPS[i][9:0]));
         end
      end
      check(!data_present, "R2 empty after drain", 32'(data_present), 32'h0);

      // R5 wait timing
      @(negedge clk);
      reg_en_async = 1'b1;
      oe_n_async = 1'b0;
      nedges(2);
      check(!bus_wait, "R5 wait not yet", 32'(bus_wait), 32'h0);
      @(negedge clk);
      check(bus_wait, "R5 wait cycle 1", 32'(bus_wait), 32'h1);
      @(negedge clk);
      check(bus_wait, "R5 wait cycle 2", 32'(bus_wait), 32'h1);
      @(negedge clk);
      check(!bus_wait, "R5 wait ended", 32'(bus_wait), 32'h0);
      // R4 late arrival during empty access
      push_byte(8'h77);
      oe_n_async = 1'b1;
      reg_en_async = 1'b0;
      nedges(6);
      check(data_present && rd_word[7:0] == 8'h77, "R4 late byte kept",
            rd_word, 32'h177);
      access(w);
      check(w[9:0] == 10'h177, "R4 late byte read", w, 32'h177);
      check(!data_present, "R4 late byte popped", 32'(data_present), 32'h0);

      // R10 one pop per access
      push_byte(8'h11);
      push_byte(8'h22);
      access(w);
      check(w[9:0] == 10'h111, "R10 first read", w, 32'h111);
      @(negedge clk);
      oe_n_async = 1'b0;
      nedges(5);
      oe_n_async = 1'b1;
      nedges(6);
      check(rd_word[9:0] == 10'h122, "R10 bare strobe no pop", rd_word, 32'h122);
      access(w);
      check(w[9:0] == 10'h122 && !data_present, "R10 second read", w, 32'h122);

      // R7 fill, overflow drop
      for (int i = 0; i < 16; i++) push_byte(8'(8'h10 + i));
      check(rd_word[9] == 1'b0, "R7 no overrun at full", rd_word, 32'h110);
      push_byte(8'hEE);
      check(rd_word[9:0] == 10'h310, "R7 overrun set", rd_word, 32'h310);
      // R6 same-edge push and pop while full
      @(negedge clk);
      oe_n_async = 1'b0;
      reg_en_async = 1'b1;
      nedges(5);
      w = rd_word;
      check(w[9:0] == 10'h310, "R7 read during overrun", w, 32'h310);
      oe_n_async = 1'b1;
      reg_en_async = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rx_byte_valid = 1'b1;
      rx_byte = 8'hF0;
      @(negedge clk);
      rx_byte_valid = 1'b0;
      nedges(3);
      check(rd_word[9:0] == 10'h111, "R6 R7 pop with push, overrun cleared",
            rd_word, 32'h111);
      for (int i = 0; i < 15; i++) begin
         logic [7:0] e;
         e = 8'(8'h11 + i);
         access(w);
         check(w[7:0] == e && w[8], "R6 drain order", w, {24'h1, e});
      end
      access(w);
      check(w[9:0] == 10'h1F0, "R6 same-edge byte kept", w, 32'h1F0);
      check(!data_present, "R6 empty at end", 32'(data_present), 32'h0);

      // R9 reset clears contents
      push_byte(8'h99);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(!data_present && rd_word == 32'h0, "R9 reset empties", rd_word, 32'h0);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule